// File: doc/BRIEF.md
# Sampled Instruction Profile Capture

This block follows one tagged instruction through a pipeline and records what happened to it. When the tagged instruction is fetched, the block opens a counting window. Counter 0 adds up an event strobe on every cycle of that window. How the instruction finishes (trap, retire, abort or squash) starts a short fixed tail. When the tail ends, the block copies the instruction's address and its outcome flags into registers that software can read. It then raises the profiling interrupt and holds counter 0 and the captured fields until software writes the control register again.

Counter 1 is a free-running 20-bit event counter with an enable bit. When it wraps, it raises its own interrupt summary bit. A single control write loads both counters, sets the counter-1 enable, clears the interrupt bits and the captured status, and arms the block for the next sample. A combinational read port returns the sampled PC, the status word, the counters or the interrupt bits.

Top module: `sprof_capture`

## Requirements
- R1: After reset, the interrupt bits, both counters, the sampled PC, the status word and the counter-1 enable read as zero, and the block is armed.
- R2: A cycle with `ctl_wr` high loads counter 0 from `ctl_wdata[19:0]`, loads counter 1 from `ctl_wdata[39:20]`, sets the counter-1 enable from `ctl_wdata[40]`, clears `irq_sum`, the status word and the sampled PC, and re-arms the block. All of this is visible at the next edge.
- R3: While the block is armed, `cnt_ev0` has no effect. A `tag_fetch` cycle opens the window. Counter 0 then adds one for each `cnt_ev0` cycle, starting with the cycle after the fetch.
- R4: The first of `tag_trap`, `tag_retire`, `tag_abort` or `tag_squash` inside an open window closes it. Counter 0 still counts in that cycle and in the two cycles after it. `irq_sum[0]` rises at the third clock edge after the closing event.
- R5: Once `irq_sum[0]` is set, counter 0 stays frozen whatever `cnt_ev0` does, until the next control write.
- R6: Status word bit layout (read select 1): [0] fetched in an instruction-cache fill stream, [1] trapped, [2] branch mispredict, [6:3] trap type, [7] load-store order replay, [8] counter-0 overcount, [9] retired valid, [10] branch taken, [11] stalled between fetch and map, [12] killed at or before map.
- R7: A trap in the window records the mispredict flag, the replay flag and the trap type. It sets the trapped bit only if `tag_shadow` is low. A retire in the same cycle as a trap also sets retired-valid, together with the taken flag from `tag_taken`.
- R8: If counter 0 wraps from all ones to zero while counting, the status word's overcount bit is set at capture.
- R9: When counter 1 is enabled, it adds one per `cnt_ev1` cycle in any window state. When it is disabled, `cnt_ev1` has no effect. A wrap of counter 1 from all ones to zero sets `irq_sum[1]`.
- R10: `irq` is high exactly when either `irq_sum` bit is high.
- R11: After capture, the sampled PC and the status word do not change in response to fetch, trap or retire strobes until the next control write.
- R12: Read select 0 returns the sampled PC. Select 1 returns the status word, zero-extended. Select 2 returns {enable, counter 1, counter 0} in bits [40:0]. Select 3 returns `irq_sum` in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 41 | Control write data: counter preloads and counter-1 enable |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 64 | Read data for the selected register |
| tag_fetch | input | 1 | Tagged instruction fetched |
| tag_pc | input | 64 | PC of the tagged instruction, valid with `tag_fetch` |
| tag_icfill | input | 1 | Fetch came from an instruction-cache fill stream |
| tag_stall | input | 1 | Tagged instruction stalled between fetch and map this cycle |
| tag_kill | input | 1 | Tagged instruction killed at or before map |
| tag_trap | input | 1 | Tagged instruction traps this cycle |
| tag_shadow | input | 1 | Trap lies in the shadow of a younger trapping instruction |
| tag_mispred | input | 1 | Trap is a conditional branch mispredict |
| tag_ttype | input | 4 | Trap type code |
| tag_lso | input | 1 | Trap is a load-store order replay |
| tag_retire | input | 1 | Tagged instruction retires this cycle |
| tag_taken | input | 1 | Branch direction, valid with `tag_retire` |
| tag_abort | input | 1 | Tagged instruction aborts this cycle |
| tag_squash | input | 1 | Tagged instruction would have retired or aborted now but is squashed |
| cnt_ev0 | input | 1 | Event strobe for counter 0 |
| cnt_ev1 | input | 1 | Event strobe for counter 1 |
| irq_sum | output | 2 | Interrupt summary bits: [0] sample done, [1] counter-1 wrap |
| irq | output | 1 | Profiling interrupt request |

## Verification
Control writes, counter steps and the read port each show their result one edge after the input cycle. The capture and `irq_sum[0]` show up three edges after the closing event. The bench drives every input at a falling edge and reads at later falling edges. It counts edges from the closing cycle, checks that `irq_sum[0]` is still low after the first and second edges and high after the third, and only then compares the counter and the status word. After capture it keeps driving event and outcome strobes for several more cycles and reads again, to confirm the frozen values.

// File: rtl/sprof_pkg.sv
package sprof_pkg;

    localparam int TT_W = 4;

    typedef enum logic [1:0] {
        W_ARMED  = 2'd0,
        W_OPEN   = 2'd1,
        W_TAIL   = 2'd2,
        W_HELD   = 2'd3
    } win_st_e;

    typedef enum logic [1:0] {
        RS_PC     = 2'd0,
        RS_STAT   = 2'd1,
        RS_CTRS   = 2'd2,
        RS_IRQ    = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic            killed;
        logic            stalled;
        logic            taken;
        logic            retired;
        logic            ovr;
        logic            lso;
        logic [TT_W-1:0] ttype;
        logic            mispred;
        logic            trapped;
        logic            icfill;
    } prof_stat_t;

    localparam int STAT_W = $bits(prof_stat_t);

endpackage

// File: rtl/sprof_ctr.sv
module sprof_ctr #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         wrap
);

    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        wrap  = 1'b0;
        if (load) begin
            val_d = load_val;
        end else if (inc) begin
            val_d = val_q + 1'b1;
            wrap  = (val_q == ALL_ONES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;

endmodule

// File: rtl/sprof_window.sv
module sprof_window
    import sprof_pkg::*;
#(
    parameter int TAIL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic fetch,
    input  logic close_ev,
    output logic fetch_acc,
    output logic accept,
    output logic count_open,
    output logic close_acc,
    output logic capture
);

    localparam int TW = $clog2(TAIL + 1);
    localparam logic [TW-1:0] TMR_LOAD = TW'(TAIL - 1);

    typedef struct packed {
        win_st_e       st;
        logic [TW-1:0] tmr;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        fetch_acc  = fetch && (w_q.st == W_ARMED) && !arm;
        accept     = (w_q.st == W_OPEN) && !arm;
        count_open = ((w_q.st == W_OPEN) || (w_q.st == W_TAIL)) && !arm;
        close_acc  = accept && close_ev;
        capture    = (w_q.st == W_TAIL) && (w_q.tmr == '0) && !arm;

        w_d = w_q;
        if (arm) begin
            w_d.st  = W_ARMED;
            w_d.tmr = '0;
        end else begin
            unique case (w_q.st)
                W_ARMED: if (fetch_acc) w_d.st = W_OPEN;
                W_OPEN: begin
                    if (close_acc) begin
                        w_d.st  = W_TAIL;
                        w_d.tmr = TMR_LOAD;
                    end
                end
                W_TAIL: begin
                    if (w_q.tmr == '0) w_d.st = W_HELD;
                    else               w_d.tmr = w_q.tmr - 1'b1;
                end
                W_HELD: w_d = w_q;
                default: w_d.st = W_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.st  <= W_ARMED;
            w_q.tmr <= '0;
        end else begin
            w_q <= w_d;
        end
    end

endmodule

// File: rtl/sprof_stat.sv
module sprof_stat
    import sprof_pkg::*;
#(
    parameter int PCW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            fetch_acc,
    input  logic [PCW-1:0]  pc_in,
    input  logic            icfill,
    input  logic            accept,
    input  logic            stall,
    input  logic            kill,
    input  logic            trap,
    input  logic            shadow,
    input  logic            mispred,
    input  logic [TT_W-1:0] ttype,
    input  logic            lso,
    input  logic            retire,
    input  logic            taken,
    input  logic            wrap0,
    input  logic            capture,
    output logic [PCW-1:0]  pc_o,
    output prof_stat_t      stat_o
);

    typedef struct packed {
        logic [PCW-1:0] pc_col;
        prof_stat_t     col;
        logic [PCW-1:0] pc_vis;
        prof_stat_t     vis;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fetch_acc) begin
            s_d.col        = '0;
            s_d.col.icfill = icfill;
            s_d.pc_col     = pc_in;
        end
        if (accept) begin
            s_d.col.stalled = s_q.col.stalled | stall;
            s_d.col.killed  = s_q.col.killed | kill;
            if (trap) begin
                s_d.col.trapped = s_q.col.trapped | !shadow;
                s_d.col.mispred = s_q.col.mispred | mispred;
                s_d.col.lso     = s_q.col.lso | lso;
                s_d.col.ttype   = ttype;
            end
            if (retire) begin
                s_d.col.retired = 1'b1;
                s_d.col.taken   = taken;
            end
        end
        if (wrap0) s_d.col.ovr = 1'b1;
        if (capture) begin
            s_d.vis    = s_d.col;
            s_d.pc_vis = s_d.pc_col;
        end
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pc_o   = s_q.pc_vis;
    assign stat_o = s_q.vis;

endmodule

// File: rtl/sprof_capture.sv
module sprof_capture
    import sprof_pkg::*;
#(
    parameter int CW   = 20,
    parameter int PCW  = 64,
    parameter int TAIL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [2*CW:0]     ctl_wdata,
    input  logic [1:0]        rd_sel,
    output logic [PCW-1:0]    rd_data,
    input  logic              tag_fetch,
    input  logic [PCW-1:0]    tag_pc,
    input  logic              tag_icfill,
    input  logic              tag_stall,
    input  logic              tag_kill,
    input  logic              tag_trap,
    input  logic              tag_shadow,
    input  logic              tag_mispred,
    input  logic [TT_W-1:0]   tag_ttype,
    input  logic              tag_lso,
    input  logic              tag_retire,
    input  logic              tag_taken,
    input  logic              tag_abort,
    input  logic              tag_squash,
    input  logic              cnt_ev0,
    input  logic              cnt_ev1,
    output logic [1:0]        irq_sum,
    output logic              irq
);

    localparam int NCTR   = 2;
    localparam int EN1_BIT = NCTR * CW;
    localparam int CTRS_W = NCTR * CW + 1;

    typedef struct packed {
        logic       en1;
        logic [1:0] sum;
    } top_t;

    top_t t_d, t_q;

    logic            fetch_acc, accept, count_open, close_acc, capture;
    logic            close_ev;
    logic [NCTR-1:0] ctr_inc, ctr_wrap;
    logic [CW-1:0]   ctr_val [NCTR];
    logic [PCW-1:0]  pc_vis;
    prof_stat_t      stat_vis;

    assign close_ev = tag_trap | tag_retire | tag_abort | tag_squash;

    sprof_window #(.TAIL(TAIL)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (ctl_wr),
        .fetch      (tag_fetch),
        .close_ev   (close_ev),
        .fetch_acc  (fetch_acc),
        .accept     (accept),
        .count_open (count_open),
        .close_acc  (close_acc),
        .capture    (capture)
    );

    assign ctr_inc[0] = cnt_ev0 & count_open;
    assign ctr_inc[1] = cnt_ev1 & t_q.en1;

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        sprof_ctr #(.W(CW)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ctl_wr),
            .load_val (ctl_wdata[i*CW +: CW]),
            .inc      (ctr_inc[i]),
            .val      (ctr_val[i]),
            .wrap     (ctr_wrap[i])
        );
    end

    sprof_stat #(.PCW(PCW)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctl_wr),
        .fetch_acc (fetch_acc),
        .pc_in     (tag_pc),
        .icfill    (tag_icfill),
        .accept    (accept),
        .stall     (tag_stall),
        .kill      (tag_kill),
        .trap      (tag_trap),
        .shadow    (tag_shadow),
        .mispred   (tag_mispred),
        .ttype     (tag_ttype),
        .lso       (tag_lso),
        .retire    (tag_retire),
        .taken     (tag_taken),
        .wrap0     (ctr_wrap[0]),
        .capture   (capture),
        .pc_o      (pc_vis),
        .stat_o    (stat_vis)
    );

    always_comb begin
        t_d = t_q;
        if (ctl_wr) begin
            t_d.en1 = ctl_wdata[EN1_BIT];
            t_d.sum = '0;
        end else begin
            t_d.sum[0] = t_q.sum[0] | capture;
            t_d.sum[1] = t_q.sum[1] | ctr_wrap[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel_e'(rd_sel))
            RS_PC:   rd_data = pc_vis;
            RS_STAT: rd_data[STAT_W-1:0] = stat_vis;
            RS_CTRS: rd_data[CTRS_W-1:0] = {t_q.en1, ctr_val[1], ctr_val[0]};
            RS_IRQ:  rd_data[1:0] = t_q.sum;
            default: rd_data = '0;
        endcase
    end

    assign irq_sum = t_q.sum;
    assign irq     = |t_q.sum;

endmodule

// File: rtl/sprof_capture_chk.sv
module sprof_capture_chk
    import sprof_pkg::*;
#(
    parameter int CW  = 20,
    parameter int PCW = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ctl_wr,
    input logic           close_acc,
    input logic [1:0]     irq_sum,
    input logic [CW-1:0]  cnt0,
    input logic [CW-1:0]  cnt1,
    input prof_stat_t     stat,
    input logic [PCW-1:0] pc
);

    localparam logic [CW-1:0] CMAX = '1;

    assert_ctl_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (irq_sum == 2'b00) && (stat == '0) && (pc == '0));

    assert_done_three_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_sum[0]) |-> $past(close_acc, 3));

    assert_cnt0_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sum[0] && !ctl_wr) |=> $stable(cnt0));

    assert_status_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sum[0] && !ctl_wr) |=> ($stable(stat) && $stable(pc)));

    assert_cnt1_wrap_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctl_wr) && ($past(cnt1) == CMAX) && (cnt1 == '0)) |-> irq_sum[1]);

endmodule

bind sprof_capture sprof_capture_chk #(.CW(CW), .PCW(PCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .close_acc (close_acc),
    .irq_sum   (irq_sum),
    .cnt0      (ctr_val[0]),
    .cnt1      (ctr_val[1]),
    .stat      (stat_vis),
    .pc        (pc_vis)
);

// File: tb/sprof_capture_tb.sv
module sprof_capture_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr;
    logic [40:0] ctl_wdata;
    logic [1:0]  rd_sel;
    logic [63:0] rd_data;
    logic        tag_fetch, tag_icfill, tag_stall, tag_kill, tag_trap, tag_shadow;
    logic        tag_mispred, tag_lso, tag_retire, tag_taken, tag_abort, tag_squash;
    logic [63:0] tag_pc;
    logic [3:0]  tag_ttype;
    logic        cnt_ev0, cnt_ev1;
    logic [1:0]  irq_sum;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    sprof_capture u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data), .tag_fetch(tag_fetch), .tag_pc(tag_pc),
        .tag_icfill(tag_icfill), .tag_stall(tag_stall), .tag_kill(tag_kill),
        .tag_trap(tag_trap), .tag_shadow(tag_shadow), .tag_mispred(tag_mispred),
        .tag_ttype(tag_ttype), .tag_lso(tag_lso), .tag_retire(tag_retire),
        .tag_taken(tag_taken), .tag_abort(tag_abort), .tag_squash(tag_squash),
        .cnt_ev0(cnt_ev0), .cnt_ev1(cnt_ev1), .irq_sum(irq_sum), .irq(irq)
    );

    always #10 clk = ~clk;

    // kind: 0 retire, 1 trap, 2 abort, 3 squash
    typedef struct packed {
        logic [63:0] pc;
        logic [1:0]  kind;
        logic [3:0]  n;
        logic        icfill, shadow, mispred;
        logic [3:0]  tt;
        logic        lso, taken, stall, kill;
        logic [19:0] pre;
        logic [12:0] exp_st;
        logic [19:0] exp_c0;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_1234_5678_9ABC, 2'd0, 4'd3, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00010, 13'h0E01, 20'h00016},
        '{64'h0000_0000_0000_2000, 2'd1, 4'd1, 1'b0, 1'b0, 1'b1, 4'hA, 1'b0, 1'b0, 1'b0, 1'b0, 20'hFFFFE, 13'h0156, 20'h00002},
        '{64'hFFFF_0000_0000_0040, 2'd2, 4'd0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00100, 13'h1800, 20'h00103},
        '{64'h8000_0000_0000_0000, 2'd1, 4'd2, 1'b1, 1'b1, 1'b0, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 20'h12345, 13'h0099, 20'h1234A},
        '{64'h0000_0000_0000_0040, 2'd3, 4'd5, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 13'h0000, 20'h00008}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [63:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic idle_in();
        ctl_wr = 0; ctl_wdata = '0; tag_fetch = 0; tag_pc = '0; tag_icfill = 0;
        tag_stall = 0; tag_kill = 0; tag_trap = 0; tag_shadow = 0; tag_mispred = 0;
        tag_ttype = '0; tag_lso = 0; tag_retire = 0; tag_taken = 0; tag_abort = 0;
        tag_squash = 0; cnt_ev0 = 0; cnt_ev1 = 0;
    endtask

    task automatic ctl(input logic en1, input logic [19:0] p1, input logic [19:0] p0);
        @(negedge clk);
        idle_in();
        ctl_wr = 1; ctl_wdata = {en1, p1, p0};
        @(negedge clk);
        idle_in();
    endtask

    task automatic run_vec(input vec_t v);
        logic [63:0] r;
        ctl(1'b0, 20'h0, v.pre);
        tag_fetch = 1; tag_pc = v.pc; tag_icfill = v.icfill;
        for (int i = 0; i < int'(v.n); i++) begin
            @(negedge clk);
            idle_in();
            cnt_ev0 = 1;
            if (i == 0) begin tag_stall = v.stall; tag_kill = v.kill; end
        end
        @(negedge clk);
        idle_in();
        cnt_ev0 = 1;
        if (v.n == 0) begin tag_stall = v.stall; tag_kill = v.kill; end
        case (v.kind)
            2'd0: begin tag_retire = 1; tag_taken = v.taken; end
            2'd1: begin tag_trap = 1; tag_shadow = v.shadow; tag_mispred = v.mispred;
                        tag_ttype = v.tt; tag_lso = v.lso; end
            2'd2: tag_abort = 1;
            default: tag_squash = 1;
        endcase
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            idle_in();
            cnt_ev0 = 1;
            chk("R4 irq timing", {63'd0, irq_sum[0]}, (k == 3) ? 64'd1 : 64'd0);
        end
        chk("R10 irq line", {63'd0, irq}, 64'd1);
        rd(2'd2, r); chk("R3/R4 counter 0", {44'd0, r[19:0]}, {44'd0, v.exp_c0});
        rd(2'd1, r); chk("R6/R7/R8 status", r, {51'd0, v.exp_st});
        rd(2'd0, r); chk("R12 sampled pc", r, v.pc);
        // post-capture activity
        tag_trap = 1; tag_ttype = 4'hF; tag_retire = 1; tag_taken = 1;
        tag_fetch = 1; tag_pc = 64'hDEAD; tag_stall = 1; tag_kill = 1;
        repeat (3) @(negedge clk);
        idle_in();
        rd(2'd2, r); chk("R5 counter 0 frozen", {44'd0, r[19:0]}, {44'd0, v.exp_c0});
        rd(2'd1, r); chk("R11 status frozen", r, {51'd0, v.exp_st});
        rd(2'd0, r); chk("R11 pc frozen", r, v.pc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] r;
        idle_in();
        rd_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), r);
            chk("R1 reset read", r, 64'd0);
        end
        chk("R1 reset irq", {63'd0, irq}, 64'd0);

        // vector table
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R3: armed window ignores cnt_ev0
        ctl(1'b0, 20'h0, 20'h00005);
        cnt_ev0 = 1;
        repeat (3) @(negedge clk);
        idle_in();
        rd(2'd2, r); chk("R3 armed ignores ev0", {44'd0, r[19:0]}, 64'h5);

        // R9: counter 1 enabled, wraps and flags
        ctl(1'b1, 20'hFFFFD, 20'h0);
        cnt_ev1 = 1;
        repeat (2) @(negedge clk);
        chk("R9 no flag before wrap", {62'd0, irq_sum}, 64'd0);
        repeat (3) @(negedge clk);
        idle_in();
        rd(2'd2, r); chk("R9 counter 1 value", r, {23'd0, 1'b1, 20'h00002, 20'h0});
        chk("R9 wrap flag", {62'd0, irq_sum}, 64'd2);
        chk("R10 irq from counter 1", {63'd0, irq}, 64'd1);
        rd(2'd3, r); chk("R12 irq read", r, 64'd2);

        // R9: counter 1 disabled
        ctl(1'b0, 20'h00077, 20'h0);
        cnt_ev1 = 1;
        repeat (4) @(negedge clk);
        idle_in();
        rd(2'd2, r); chk("R9 disabled ignores ev1", r, {23'd0, 1'b0, 20'h00077, 20'h0});
        chk("R2 write cleared irq", {63'd0, irq}, 64'd0);

        // R7: trap and retire in one cycle
        ctl(1'b0, 20'h0, 20'h0);
        tag_fetch = 1; tag_pc = 64'h100;
        @(negedge clk);
        idle_in();
        tag_trap = 1; tag_retire = 1;
        repeat (3) @(negedge clk);
        idle_in();
        rd(2'd1, r); chk("R7 trap plus retire", r, 64'h202);

        // R2: control write clears everything and loads counter 0
        ctl(1'b0, 20'h0, 20'hABCDE);
        chk("R2 irq_sum cleared", {62'd0, irq_sum}, 64'd0);
        rd(2'd1, r); chk("R2 status cleared", r, 64'd0);
        rd(2'd0, r); chk("R2 pc cleared", r, 64'd0);
        rd(2'd2, r); chk("R2 counter 0 loaded", r, 64'hABCDE);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule